// File: doc/BRIEF.md
# Grouped Channel Interrupt Aggregator

This block gathers request pulses from eight capture/compare timer channels and from a base counter. It reduces them to three interrupt flags for an interrupt controller: two shared group lines and one base-timer line. It also issues one DMA request strobe for each of the nine sources. Each channel pulse sets a sticky pending bit. Two independent enable masks select which pending channels feed each group line.

A group flag is raised only on the cycle after its masked pending set changes from empty to non-empty. A flag stays set until software clears it. Pending bits are never cleared by the hardware, so software must write them back to zero. While any masked pending bit stays set, later causes on that line are hidden. The base-timer flag is set by a counter-reset event or by a counter-overflow event.

Software reaches four registers through a simple write-strobe/address/data port with a registered read path. The registers are the pending bits (address 0), enable mask 0 (address 1), enable mask 1 (address 2) and the flags (address 3).

Top module: `chan_irq_aggregator`

## Requirements
- R1: A high on `chan_req[i]` at a clock edge sets pending bit i at that edge.
- R2: A write to address 0 clears every pending bit whose data bit is 0 and keeps every bit whose data bit is 1. A channel request in the same cycle as a clearing write leaves that bit set.
- R3: Pending bits change only through R1 and R2: flag writes, mask writes and the raising of interrupt flags leave them unchanged.
- R4: `irq_grp0` is set one edge after (pending AND mask 0) goes from all-zero to non-zero. Mask 0 is written at address 1. The flag never rises while that masked set is zero.
- R5: `irq_grp1` behaves as R4 using mask 1 at address 2, independently of mask 0, so one channel can raise both lines. Enabling a mask bit for a channel that is already pending also counts as a rise.
- R6: While the masked pending set of a group stays non-zero, new channel requests do not raise that group's flag again after software has cleared it.
- R7: `irq_base` is set at the edge after `base_rst_req` or `base_ovf_req` is high.
- R8: A write to address 3 clears the flags whose data bit is 0: bit 0 clears `irq_grp0`, bit 1 clears `irq_grp1` and bit 2 clears `irq_base`. A data bit of 1 leaves its flag unchanged. A set event in the same cycle wins over the clear.
- R9: `dma_req[i]` (i < 8) is high for exactly the one cycle after the edge that sampled `chan_req[i]` high. `dma_req[8]` does the same for the base events. Neither depends on the masks or on the pending state.
- R10: A synchronous active-high `rst` clears the pending bits, both masks, all three flags, `dma_req` and `reg_rdata`.
- R11: `reg_rdata` shows, one edge after `reg_addr` is presented, the register at that address. Address 3 reads as {0, irq_base, irq_grp1, irq_grp0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 8 | Channel request pulses |
| base_rst_req | input | 1 | Base counter reset event |
| base_ovf_req | input | 1 | Base counter overflow event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_grp0 | output | 1 | Shared interrupt flag 0 |
| irq_grp1 | output | 1 | Shared interrupt flag 1 |
| irq_base | output | 1 | Base-timer interrupt flag |
| dma_req | output | 9 | DMA request strobes, bit 8 for the base timer |

## Verification
The checker watches, on every cycle, the rules that hold at every edge. A request always lands in the pending bits. Pending bits never drop without a write to address 0. A group flag cannot rise while its masked pending set is empty. A flag holds until a clearing write. The base flag follows its events, and each DMA strobe mirrors its source one edge later. The bench's scenarios cover what depends on history: the hidden causes while bits remain pending, a mask write that raises a flag, set-over-clear collisions, one channel driving both lines, and register readback after reset.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NUM_GRP = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND  = 2'd0,
    REG_MASK0 = 2'd1,
    REG_MASK1 = 2'd2,
    REG_FLAGS = 2'd3
  } reg_sel_e;

  localparam int unsigned FLAG_GRP0 = 0;
  localparam int unsigned FLAG_GRP1 = 1;
  localparam int unsigned FLAG_BASE = 2;
endpackage

// File: rtl/cia_pending.sv
module cia_pending #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] pend
);
  logic [NUM_CH-1:0] kept;

  // zero in write data clears, one keeps; arriving requests override
  always_comb begin
    kept = wr_en ? (pend & wdata) : pend;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= kept | req;
  end
endmodule

// File: rtl/cia_group_line.sv
module cia_group_line #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend,
  input  logic              mask_wr,
  input  logic [NUM_CH-1:0] mask_wdata,
  input  logic              flag_clr,
  output logic [NUM_CH-1:0] mask,
  output logic              flag
);
  logic any_now;
  logic any_q;

  assign any_now = |(pend & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      any_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (mask_wr) mask <= mask_wdata;
      any_q <= any_now;
      if (any_now && !any_q) flag <= 1'b1;
      else if (flag_clr)     flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cia_event_flag.sv
module cia_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/cia_dma_strobe.sv
module cia_dma_strobe #(
  parameter int unsigned NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ev,
  output logic [NUM_SRC-1:0] strb
);
  always_ff @(posedge clk) begin
    if (rst) strb <= '0;
    else     strb <= ev;
  end
endmodule

// File: rtl/chan_irq_aggregator.sv
module chan_irq_aggregator
  import chan_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              base_rst_req,
  input  logic              base_ovf_req,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [NUM_CH-1:0] reg_rdata,
  output logic              irq_grp0,
  output logic              irq_grp1,
  output logic              irq_base,
  output logic [NUM_CH:0]   dma_req
);
  localparam int unsigned NUM_SRC = NUM_CH + 1;

  logic [NUM_CH-1:0]  pend_q;
  logic [NUM_CH-1:0]  mask_q [NUM_GRP];
  logic [NUM_GRP-1:0] grp_flag;
  logic [NUM_CH-1:0]  mask0_q;
  logic [NUM_CH-1:0]  mask1_q;
  logic               wr_pend;
  logic               wr_flags;
  logic               base_ev;
  logic [NUM_CH-1:0]  flags_view;

  assign wr_pend  = reg_wr_en && (reg_addr == REG_PEND);
  assign wr_flags = reg_wr_en && (reg_addr == REG_FLAGS);
  assign base_ev  = base_rst_req || base_ovf_req;

  cia_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .req   (chan_req),
    .wr_en (wr_pend),
    .wdata (reg_wdata),
    .pend  (pend_q)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic mask_wr;
    logic flag_clr;
    assign mask_wr  = reg_wr_en && (reg_addr == ADDR_W'(g + 1));
    assign flag_clr = wr_flags && !reg_wdata[g];
    cia_group_line #(.NUM_CH(NUM_CH)) u_line (
      .clk        (clk),
      .rst        (rst),
      .pend       (pend_q),
      .mask_wr    (mask_wr),
      .mask_wdata (reg_wdata),
      .flag_clr   (flag_clr),
      .mask       (mask_q[g]),
      .flag       (grp_flag[g])
    );
  end

  cia_event_flag u_base (
    .clk  (clk),
    .rst  (rst),
    .set  (base_ev),
    .clr  (wr_flags && !reg_wdata[FLAG_BASE]),
    .flag (irq_base)
  );

  cia_dma_strobe #(.NUM_SRC(NUM_SRC)) u_dma (
    .clk  (clk),
    .rst  (rst),
    .ev   ({base_ev, chan_req}),
    .strb (dma_req)
  );

  assign mask0_q  = mask_q[0];
  assign mask1_q  = mask_q[1];
  assign irq_grp0 = grp_flag[FLAG_GRP0];
  assign irq_grp1 = grp_flag[FLAG_GRP1];

  always_comb begin
    flags_view = '0;
    flags_view[FLAG_GRP0] = grp_flag[FLAG_GRP0];
    flags_view[FLAG_GRP1] = grp_flag[FLAG_GRP1];
    flags_view[FLAG_BASE] = irq_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        REG_PEND:  reg_rdata <= pend_q;
        REG_MASK0: reg_rdata <= mask0_q;
        REG_MASK1: reg_rdata <= mask1_q;
        default:   reg_rdata <= flags_view;
      endcase
    end
  end
endmodule

// File: rtl/chan_irq_checker.sv
module chan_irq_checker #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_req,
  input logic              base_rst_req,
  input logic              base_ovf_req,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [2:0]        flag_wd,
  input logic              irq_grp0,
  input logic              irq_grp1,
  input logic              irq_base,
  input logic [NUM_CH:0]   dma_req,
  input logic [NUM_CH-1:0] pend_q,
  input logic [NUM_CH-1:0] mask0_q,
  input logic [NUM_CH-1:0] mask1_q
);
  p_pend_set_r1: assert property (@(posedge clk) disable iff (rst)
    (|chan_req) |=> ((pend_q & $past(chan_req)) == $past(chan_req)));

  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_addr == 2'd0) |=> ((~pend_q & $past(pend_q)) == '0));

  p_grp0_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (!irq_grp0 && ((pend_q & mask0_q) == '0)) |=> !irq_grp0);

  p_grp1_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq_grp1 && ((pend_q & mask1_q) == '0)) |=> !irq_grp1);

  p_grp0_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_grp0 && !(reg_wr_en && reg_addr == 2'd3 && !flag_wd[0])) |=> irq_grp0);

  p_grp1_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_grp1 && !(reg_wr_en && reg_addr == 2'd3 && !flag_wd[1])) |=> irq_grp1);

  p_base_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_base && !(reg_wr_en && reg_addr == 2'd3 && !flag_wd[2])) |=> irq_base);

  p_base_set_r7: assert property (@(posedge clk) disable iff (rst)
    (base_rst_req || base_ovf_req) |=> irq_base);

  p_dma_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dma_req == {$past(base_rst_req || base_ovf_req), $past(chan_req)}));
endmodule

bind chan_irq_aggregator chan_irq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .chan_req     (chan_req),
  .base_rst_req (base_rst_req),
  .base_ovf_req (base_ovf_req),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .flag_wd      (reg_wdata[2:0]),
  .irq_grp0     (irq_grp0),
  .irq_grp1     (irq_grp1),
  .irq_base     (irq_base),
  .dma_req      (dma_req),
  .pend_q       (pend_q),
  .mask0_q      (mask0_q),
  .mask1_q      (mask1_q)
);

// File: tb/tb_chan_irq_aggregator.sv
module tb_chan_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] chan_req = '0;
  logic       base_rst_req = 1'b0;
  logic       base_ovf_req = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_grp0, irq_grp1, irq_base;
  logic [8:0] dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_irq_aggregator dut (
    .clk(clk), .rst(rst), .chan_req(chan_req),
    .base_rst_req(base_rst_req), .base_ovf_req(base_ovf_req),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_grp0(irq_grp0), .irq_grp1(irq_grp1),
    .irq_base(irq_base), .dma_req(dma_req)
  );

  // {chan_req, base_rst_req, base_ovf_req, expected dma_req}
  localparam logic [18:0] VECS [0:5] = '{
    {8'h01, 1'b0, 1'b0, 9'h001},
    {8'h80, 1'b0, 1'b0, 9'h080},
    {8'h00, 1'b1, 1'b0, 9'h100},
    {8'h00, 1'b0, 1'b1, 9'h100},
    {8'h24, 1'b1, 1'b1, 9'h124},
    {8'h00, 1'b0, 1'b0, 9'h000}
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    cyc();
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] c, input logic br, input logic bo);
    chan_req = c; base_rst_req = br; base_ovf_req = bo;
    cyc();
    chan_req = '0; base_rst_req = 1'b0; base_ovf_req = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    // R10: reset state
    chk("R10 flags", {irq_base, irq_grp1, irq_grp0}, 3'b000);
    chk("R10 dma", dma_req, 9'h000);
    rd(2'd0, v); chk("R10 pend", v, 8'h00);

    // R9 and R1: vector table, masks still zero
    for (int i = 0; i < 6; i++) begin
      pulse(VECS[i][18:11], VECS[i][10], VECS[i][9]);
      chk("R9 dma strobe", dma_req, VECS[i][8:0]);
      cyc();
      chk("R9 dma single cycle", dma_req, 9'h000);
    end
    rd(2'd0, v); chk("R1 pending accumulated", v, 8'hA5);
    chk("R4 no group flag without mask", {irq_grp1, irq_grp0}, 2'b00);
    chk("R7 base flag", irq_base, 1'b1);

    // R8: clear base only
    wr(2'd3, 8'h03);
    chk("R8 base cleared", irq_base, 1'b0);
    rd(2'd3, v); chk("R11 flags read", v, 8'h00);
    rd(2'd0, v); chk("R3 pending kept after flag write", v, 8'hA5);

    // R2: write-zero-to-clear and set wins
    wr(2'd0, 8'hF0);
    rd(2'd0, v); chk("R2 partial clear", v, 8'hA0);
    chan_req = 8'h01;
    wr(2'd0, 8'h00);
    chan_req = 8'h00;
    rd(2'd0, v); chk("R2 set wins over clear", v, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R2 full clear", v, 8'h00);

    // R4: group 0 raised by channel 1
    wr(2'd1, 8'h0F);
    pulse(8'h02, 1'b0, 1'b0);
    cyc();
    chk("R4 grp0 raised", irq_grp0, 1'b1);
    chk("R5 grp1 independent", irq_grp1, 1'b0);

    // R6: cleared flag stays low while pending remains
    wr(2'd3, 8'h06);
    chk("R8 grp0 cleared", irq_grp0, 1'b0);
    pulse(8'h04, 1'b0, 1'b0);
    cyc(); cyc();
    chk("R6 hidden cause", irq_grp0, 1'b0);
    wr(2'd0, 8'h00);
    pulse(8'h08, 1'b0, 1'b0);
    cyc();
    chk("R4 raised after pending cleared", irq_grp0, 1'b1);

    // R5: mask write on an already pending channel
    wr(2'd2, 8'h08);
    cyc();
    chk("R5 grp1 raised by mask write", irq_grp1, 1'b1);
    rd(2'd2, v); chk("R11 mask1 read", v, 8'h08);
    rd(2'd1, v); chk("R11 mask0 read", v, 8'h0F);
    wr(2'd3, 8'h04);
    chk("R8 both groups cleared", {irq_grp1, irq_grp0}, 2'b00);
    wr(2'd0, 8'h00);
    pulse(8'h08, 1'b0, 1'b0);
    cyc();
    chk("R5 one channel on both lines", {irq_grp1, irq_grp0}, 2'b11);

    // R8: set wins over clear, write of ones keeps
    reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00; base_ovf_req = 1'b1;
    cyc();
    reg_wr_en = 1'b0; base_ovf_req = 1'b0;
    chk("R8 base set wins", irq_base, 1'b1);
    chk("R8 groups cleared", {irq_grp1, irq_grp0}, 2'b00);
    wr(2'd3, 8'h07);
    chk("R8 write ones keeps", {irq_base, irq_grp1, irq_grp0}, 3'b100);
    rd(2'd3, v); chk("R11 flags read base", v, 8'h04);

    // R10: reset clears everything
    pulse(8'hFF, 1'b0, 1'b0);
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    chk("R10 flags after reset", {irq_base, irq_grp1, irq_grp0}, 3'b000);
    rd(2'd0, v); chk("R10 pend after reset", v, 8'h00);
    rd(2'd1, v); chk("R10 mask0 after reset", v, 8'h00);
    rd(2'd2, v); chk("R10 mask1 after reset", v, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule